// File: doc/BRIEF.md
# Link Compliance Pattern Sequencer

This block produces the transmit test stimulus that a 5 Gb/s serial lane sends while it is in compliance mode. A strobe from the link-state logic starts it. It then sends one of nine test patterns, CP0 to CP8, one symbol per clock. Each pattern repeats without end. Each detected ping LFPS moves the block to the next pattern, and a ping during CP8 goes back to CP0. A link reset stops the sequence and returns the block to idle.

The block has three kinds of output, and each pattern uses one of them:

- **Symbol path:** an 8-bit symbol with a control flag. It goes to the 8b/10b encoder.
- **Raw path:** a 10-bit raw word for the long bit-run patterns. The encoder passes it through unchanged.
- **LFPS request:** a level that asks the analog side for low-frequency signalling.

A separate de-emphasis flag tells the driver which transmit setting the current pattern needs. A status index shows the current pattern number.

Top module: `cpat_seq`

## Requirements
- R1: After `rst`, and whenever the block is idle, the outputs are as follows. `pat_idx` reads 15. `sym_valid`, `raw_valid`, `lfps_en` and `deemph_en` are all 0.
- R2: A `comp_enter` pulse while idle starts CP0 at the next clock edge. It also seeds the scrambler to 0xFFFF. A `comp_enter` pulse while a pattern is running has no effect.
- R3: CP0 sends data symbols (`sym_ctrl`=0) equal to D0.0 (0x00) XOR the upper byte of a 16-bit LFSR. The LFSR is a left-shift register with new bit = s[15]^s[4]^s[3]^s[2], which is the polynomial x^16+x^5+x^4+x^3+1. It shifts eight times after each CP0 symbol and holds in every other pattern.
- R4: The pattern index advances as follows:
  - A `ping_det` high on a clock edge while a pattern runs moves `pat_idx` up by one at that edge.
  - From 8 it wraps to 0, and the scrambler is reseeded to 0xFFFF.
  - Ping high on consecutive cycles advances the index once per cycle.
  - Without a ping the index holds.
- R5: `link_rst` returns the block to idle at the next edge. It takes priority over `comp_enter` and `ping_det`.
- R6: The fixed symbol patterns are as follows, each on the symbol path:
  - CP1 sends 0x4A (D10.2) as data.
  - CP2 sends 0x78 (D24.3) as data.
  - CP3 sends 0xBC (K28.5) with `sym_ctrl`=1.
- R7: In CP4 only `lfps_en` is high. `sym_valid` and `raw_valid` are both 0.
- R8: CP5 and CP6 send 0xFC (K28.7) with `sym_ctrl`=1.
- R9: CP7 and CP8 drive `raw_valid` with a repeating stream of N ones followed by N zeros. The stream is packed LSB-first, so bit 0 of `raw_word` is the earliest bit. The stream restarts with the first one bit when the pattern is entered.
- R10: N is `run_len` clamped to the range 50 to 250. It is sampled at each edge where the pattern index changes from one running pattern to another, or from idle into CP0.
- R11: While a pattern runs, exactly one of `sym_valid`, `raw_valid` and `lfps_en` is high. The SKP character K28.1 (0x3C with `sym_ctrl`=1) is never sent.
- R12: `deemph_en` is low in CP6 and CP8 and high in every other running pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one symbol per cycle |
| rst | input | 1 | Synchronous active-high reset |
| comp_enter | input | 1 | Start compliance transmission (from idle) |
| ping_det | input | 1 | Ping LFPS detected on receive side |
| link_rst | input | 1 | Terminate compliance, go idle |
| run_len | input | 8 | Requested bit-run length for CP7/CP8 |
| sym_data | output | 8 | Symbol to the 8b/10b encoder |
| sym_ctrl | output | 1 | Symbol is a control character |
| sym_valid | output | 1 | Symbol path active |
| raw_word | output | 10 | Raw 10-bit word, LSB sent first |
| raw_valid | output | 1 | Raw path active, encoder bypassed |
| lfps_en | output | 1 | Request LFPS signalling |
| deemph_en | output | 1 | Transmit de-emphasis enable |
| pat_idx | output | 4 | Current pattern 0..8, 15 when idle |

## Verification
The assertions assume that `rst` is asserted at start-up. They also assume that `comp_enter`, `ping_det` and `link_rst` are sampled only at clock edges, so that each cycle is one symbol boundary. They assume that `run_len` is stable on the edge where it is sampled. The stimulus drives every input one nanosecond after the rising edge. It changes `run_len` only while a ping or entry is pending, and it includes values below 50 and above 250 to exercise the clamp. The stimulus also covers the following:
- pings while idle;
- a second entry while a pattern is running;
- pings on consecutive cycles;
- a link reset that coincides with a ping.

// File: rtl/cpat_pkg.sv
package cpat_pkg;

    localparam int SYM_W  = 8;
    localparam int RAW_W  = 10;
    localparam int LFSR_W = 16;

    typedef enum logic [3:0] {
        PAT_CP0  = 4'd0,
        PAT_CP1  = 4'd1,
        PAT_CP2  = 4'd2,
        PAT_CP3  = 4'd3,
        PAT_CP4  = 4'd4,
        PAT_CP5  = 4'd5,
        PAT_CP6  = 4'd6,
        PAT_CP7  = 4'd7,
        PAT_CP8  = 4'd8,
        PAT_IDLE = 4'd15
    } pat_e;

    localparam logic [SYM_W-1:0] SYM_D00  = 8'h00;
    localparam logic [SYM_W-1:0] SYM_D102 = 8'h4A;
    localparam logic [SYM_W-1:0] SYM_D243 = 8'h78;
    localparam logic [SYM_W-1:0] SYM_K285 = 8'hBC;
    localparam logic [SYM_W-1:0] SYM_K287 = 8'hFC;
    localparam logic [SYM_W-1:0] SYM_K281 = 8'h3C;

    typedef struct packed {
        logic [SYM_W-1:0] sym;
        logic             ctrl;
        logic             sym_vld;
        logic             scram;
        logic             lfps;
        logic             raw;
        logic             deemph;
    } pat_attr_t;

    function automatic pat_attr_t pattern_attr(pat_e p);
        pat_attr_t a;
        a = '0;
        a.deemph = 1'b1;
        unique case (p)
            PAT_CP0: begin a.sym = SYM_D00;  a.sym_vld = 1'b1; a.scram = 1'b1; end
            PAT_CP1: begin a.sym = SYM_D102; a.sym_vld = 1'b1; end
            PAT_CP2: begin a.sym = SYM_D243; a.sym_vld = 1'b1; end
            PAT_CP3: begin a.sym = SYM_K285; a.sym_vld = 1'b1; a.ctrl = 1'b1; end
            PAT_CP4: begin a.lfps = 1'b1; end
            PAT_CP5: begin a.sym = SYM_K287; a.sym_vld = 1'b1; a.ctrl = 1'b1; end
            PAT_CP6: begin a.sym = SYM_K287; a.sym_vld = 1'b1; a.ctrl = 1'b1; a.deemph = 1'b0; end
            PAT_CP7: begin a.raw = 1'b1; end
            PAT_CP8: begin a.raw = 1'b1; a.deemph = 1'b0; end
            default: begin a.deemph = 1'b0; end
        endcase
        return a;
    endfunction

    // One symbol worth (eight shifts) of the x^16+x^5+x^4+x^3+1 generator.
    function automatic logic [LFSR_W-1:0] lfsr_advance(logic [LFSR_W-1:0] s, int shifts);
        logic [LFSR_W-1:0] t;
        t = s;
        for (int k = 0; k < shifts; k++) begin
            t = {t[LFSR_W-2:0], t[15] ^ t[4] ^ t[3] ^ t[2]};
        end
        return t;
    endfunction

    function automatic logic [7:0] clamp_run(logic [7:0] v, int lo, int hi);
        if (int'(v) < lo) return 8'(lo);
        if (int'(v) > hi) return 8'(hi);
        return v;
    endfunction

endpackage

// File: rtl/cpat_scrambler.sv
module cpat_scrambler
    import cpat_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 16'hFFFF,
    parameter int SHIFTS_PER_SYM      = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             seed_load,
    input  logic             step,
    output logic [SYM_W-1:0] key
);
    logic [LFSR_W-1:0] state;

    always_ff @(posedge clk) begin
        if (rst || seed_load) begin
            state <= SEED;
        end else if (step) begin
            state <= lfsr_advance(state, SHIFTS_PER_SYM);
        end
    end

    assign key = state[LFSR_W-1 -: SYM_W];

    // R3
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        state != '0);

    // R2
    seed_key_chk: assert property (@(posedge clk) disable iff (rst)
        seed_load |=> key == SEED[LFSR_W-1 -: SYM_W]);

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!step && !seed_load) |=> $stable(key));
endmodule

// File: rtl/cpat_rungen.sv
module cpat_rungen
    import cpat_pkg::*;
#(
    parameter int RUN_MAX = 250,
    parameter int RUN_MIN = 50,
    parameter int RUN_W   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             advance,
    input  logic [RUN_W-1:0] run_n,
    output logic [RAW_W-1:0] raw_word
);
    localparam int PW = $clog2(2 * RUN_MAX + RAW_W + 1);

    logic [PW-1:0] pos;
    logic [PW-1:0] run_ext;
    logic [PW-1:0] period;
    logic [PW-1:0] pos_next;

    assign run_ext = PW'(run_n);
    assign period  = run_ext << 1;

    always_comb begin
        logic [PW-1:0] p;
        raw_word = '0;
        for (int i = 0; i < RAW_W; i++) begin
            p = pos + PW'(i);
            if (p >= period) p = p - period;
            raw_word[i] = (p < run_ext);
        end
        pos_next = pos + PW'(RAW_W);
        if (pos_next >= period) pos_next = pos_next - period;
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pos <= '0;
        end else if (advance) begin
            pos <= pos_next;
        end
    end

    // R9
    pos_in_period_chk: assert property (@(posedge clk) disable iff (rst)
        pos < period);

    // R9
    restart_first_one_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> raw_word[0]);

    // R10
    run_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(run_n) >= RUN_MIN && int'(run_n) <= RUN_MAX);
endmodule

// File: rtl/cpat_seq.sv
module cpat_seq
    import cpat_pkg::*;
#(
    parameter int RUN_MIN = 50,
    parameter int RUN_MAX = 250,
    parameter int RUN_W   = 8,
    parameter logic [LFSR_W-1:0] SEED = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             comp_enter,
    input  logic             ping_det,
    input  logic             link_rst,
    input  logic [RUN_W-1:0] run_len,
    output logic [SYM_W-1:0] sym_data,
    output logic             sym_ctrl,
    output logic             sym_valid,
    output logic [RAW_W-1:0] raw_word,
    output logic             raw_valid,
    output logic             lfps_en,
    output logic             deemph_en,
    output logic [3:0]       pat_idx
);
    pat_e             cur;
    pat_attr_t        attr;
    logic             active;
    logic             enter_fire;
    logic             ping_fire;
    logic             wrap;
    logic [RUN_W-1:0] run_n;
    logic [RUN_W-1:0] run_req;
    logic [SYM_W-1:0] key;
    logic [RAW_W-1:0] raw_bits;

    assign active     = (cur != PAT_IDLE);
    assign enter_fire = !link_rst && !active && comp_enter;
    assign ping_fire  = !link_rst && active && ping_det;
    assign wrap       = (cur == PAT_CP8);
    assign run_req    = RUN_W'(clamp_run(8'(run_len), RUN_MIN, RUN_MAX));
    assign attr       = pattern_attr(cur);

    always_ff @(posedge clk) begin
        if (rst || link_rst) begin
            cur <= PAT_IDLE;
        end else if (enter_fire) begin
            cur <= PAT_CP0;
        end else if (ping_fire) begin
            cur <= wrap ? PAT_CP0 : pat_e'(cur + 4'd1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_n <= RUN_W'(RUN_MIN);
        end else if (enter_fire || ping_fire) begin
            run_n <= run_req;
        end
    end

    cpat_scrambler #(.SEED(SEED), .SHIFTS_PER_SYM(8)) u_scr (
        .clk       (clk),
        .rst       (rst),
        .seed_load (enter_fire || (ping_fire && wrap)),
        .step      (attr.scram),
        .key       (key)
    );

    cpat_rungen #(.RUN_MAX(RUN_MAX), .RUN_MIN(RUN_MIN), .RUN_W(RUN_W)) u_run (
        .clk      (clk),
        .rst      (rst),
        .restart  (enter_fire || ping_fire),
        .advance  (attr.raw),
        .run_n    (run_n),
        .raw_word (raw_bits)
    );

    assign sym_data  = attr.scram ? (attr.sym ^ key) : attr.sym;
    assign sym_ctrl  = attr.ctrl;
    assign sym_valid = attr.sym_vld;
    assign raw_word  = attr.raw ? raw_bits : '0;
    assign raw_valid = attr.raw;
    assign lfps_en   = attr.lfps;
    assign deemph_en = attr.deemph;
    assign pat_idx   = 4'(cur);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (pat_idx == 4'd15) |-> !(sym_valid || raw_valid || lfps_en || deemph_en));

    // R5
    link_rst_idle_chk: assert property (@(posedge clk) disable iff (rst)
        link_rst |=> pat_idx == 4'd15);

    // R4
    ping_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ping_det && !link_rst && pat_idx < 4'd8) |=> pat_idx == $past(pat_idx) + 4'd1);

    // R4
    ping_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (ping_det && !link_rst && pat_idx == 4'd8) |=> pat_idx == 4'd0);

    // R2
    reenter_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (pat_idx != 4'd15 && !ping_det && !link_rst) |=> $stable(pat_idx));

    // R11
    one_path_chk: assert property (@(posedge clk) disable iff (rst)
        (pat_idx != 4'd15) |-> $countones({sym_valid, raw_valid, lfps_en}) == 1);

    // R11
    no_skp_chk: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && sym_ctrl) |-> sym_data != SYM_K281);
endmodule

// File: tb/cpat_seq_bench.sv
module cpat_seq_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       comp_enter = 1'b0;
    logic       ping_det = 1'b0;
    logic       link_rst = 1'b0;
    logic [7:0] run_len = 8'd50;
    logic [7:0] sym_data;
    logic       sym_ctrl, sym_valid, raw_valid, lfps_en, deemph_en;
    logic [9:0] raw_word;
    logic [3:0] pat_idx;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    cpat_seq u_cpat_seq (
        .clk(clk), .rst(rst), .comp_enter(comp_enter), .ping_det(ping_det),
        .link_rst(link_rst), .run_len(run_len), .sym_data(sym_data),
        .sym_ctrl(sym_ctrl), .sym_valid(sym_valid), .raw_word(raw_word),
        .raw_valid(raw_valid), .lfps_en(lfps_en), .deemph_en(deemph_en),
        .pat_idx(pat_idx)
    );

    // ---------------- behavioural reference model ----------------
    int          m_idx = 15;
    bit          m_act = 1'b0;
    logic [15:0] m_lfsr = 16'hFFFF;
    int          m_pos = 0;
    int          m_n = 50;

    function automatic int clampn(int v);
        return (v < 50) ? 50 : ((v > 250) ? 250 : v);
    endfunction

    function automatic logic [15:0] scr8(logic [15:0] s);
        logic [15:0] t = s;
        for (int k = 0; k < 8; k++) t = {t[14:0], t[15] ^ t[4] ^ t[3] ^ t[2]};
        return t;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_act = 0; m_idx = 15; m_pos = 0; m_n = 50; m_lfsr = 16'hFFFF;
        end else if (link_rst) begin
            m_act = 0; m_idx = 15;
        end else if (!m_act && comp_enter) begin
            m_act = 1; m_idx = 0; m_lfsr = 16'hFFFF; m_pos = 0; m_n = clampn(int'(run_len));
        end else if (m_act) begin
            if (m_idx == 0) m_lfsr = scr8(m_lfsr);
            if (ping_det) begin
                m_idx = (m_idx == 8) ? 0 : m_idx + 1;
                m_pos = 0;
                m_n = clampn(int'(run_len));
                if (m_idx == 0) m_lfsr = 16'hFFFF;
            end else if (m_idx >= 7) begin
                m_pos = (m_pos + 10) % (2 * m_n);
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cycles);
        end
    endtask

    // compare every cycle, half a period after the edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [7:0] e_sym; logic e_ctrl, e_sv, e_rv, e_lf, e_de; logic [9:0] e_raw;
            string tag;
            e_sym = 8'h00; e_ctrl = 0; e_sv = 0; e_rv = 0; e_lf = 0; e_raw = '0;
            e_de = m_act && !(m_idx == 6 || m_idx == 8);
            tag = "R1";
            case (m_idx)
                0: begin e_sym = m_lfsr[15:8]; e_sv = 1; tag = "R3"; end
                1: begin e_sym = 8'h4A; e_sv = 1; tag = "R6"; end
                2: begin e_sym = 8'h78; e_sv = 1; tag = "R6"; end
                3: begin e_sym = 8'hBC; e_ctrl = 1; e_sv = 1; tag = "R6"; end
                4: begin e_lf = 1; tag = "R7"; end
                5, 6: begin e_sym = 8'hFC; e_ctrl = 1; e_sv = 1; tag = "R8"; end
                7, 8: begin
                    e_rv = 1; tag = "R9";
                    for (int i = 0; i < 10; i++) e_raw[i] = (((m_pos + i) % (2 * m_n)) < m_n);
                end
                default: ;
            endcase
            chk("R4", 32'(pat_idx), 32'(m_idx), "pat_idx");
            chk(tag, {23'd0, sym_valid, sym_data}, {23'd0, e_sv, e_sym}, "sym_valid/sym_data");
            chk(tag, {30'd0, sym_ctrl, lfps_en}, {30'd0, e_ctrl, e_lf}, "sym_ctrl/lfps_en");
            chk(tag, {21'd0, raw_valid, raw_word}, {21'd0, e_rv, e_raw}, "raw_valid/raw_word");
            chk("R12", 32'(deemph_en), 32'(e_de), "deemph_en");
            // R11: one path, no SKP
            chk("R11", 32'(m_act ? 1 : 0), 32'($countones({sym_valid, raw_valid, lfps_en})), "path count");
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_ping();
        ping_det = 1; step(1); ping_det = 0;
    endtask

    initial begin
        step(4);
        rst = 0;
        // R1: idle after reset, ping while idle ignored
        chk("R1", 32'(pat_idx), 32'd15, "pat_idx after reset");
        chk("R1", {28'd0, sym_valid, raw_valid, lfps_en, deemph_en}, 32'd0, "flags after reset");
        pulse_ping();
        step(2);
        // R2: entry starts CP0 with seeded scrambler
        comp_enter = 1; step(1); comp_enter = 0;
        chk("R2", 32'(sym_data), 32'hFF, "first CP0 symbol");
        step(20);
        // R2: second entry while running has no effect
        comp_enter = 1; step(1); comp_enter = 0;
        chk("R2", 32'(pat_idx), 32'd0, "re-entry ignored");
        step(5);
        // walk CP1..CP6, consecutive pings from CP1 to CP3
        pulse_ping(); step(4);
        ping_det = 1; step(2); ping_det = 0;
        chk("R4", 32'(pat_idx), 32'd3, "back-to-back pings");
        step(4);
        pulse_ping(); step(6);
        pulse_ping(); step(5);
        pulse_ping(); step(5);
        // R10: CP7 with run_len below minimum -> 50
        run_len = 8'd10; pulse_ping(); run_len = 8'd200;
        step(40);
        // R10: CP8 with run_len above maximum -> 250
        run_len = 8'd255; pulse_ping(); run_len = 8'd77;
        step(120);
        // R4: wrap to CP0 with reseed
        pulse_ping();
        chk("R4", 32'(pat_idx), 32'd0, "wrap to CP0");
        chk("R4", 32'(sym_data), 32'hFF, "reseed on wrap");
        step(10);
        // go to CP7 with a mid-range length
        run_len = 8'd63;
        repeat (7) pulse_ping();
        step(30);
        // R5: link reset wins over a simultaneous ping
        link_rst = 1; ping_det = 1; step(1); link_rst = 0; ping_det = 0;
        chk("R5", 32'(pat_idx), 32'd15, "link reset to idle");
        step(3);
        // R5: link reset beats entry
        link_rst = 1; comp_enter = 1; step(1); link_rst = 0; comp_enter = 0;
        chk("R5", 32'(pat_idx), 32'd15, "link reset blocks entry");
        comp_enter = 1; step(1); comp_enter = 0;
        chk("R2", 32'(sym_data), 32'hFF, "re-entry after link reset");
        step(12);
        done = 1;
        step(1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        wait (cycles > 5000);
        if (!done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<5000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule